// File: doc/BRIEF.md
# Return Address Stack Predictor

This block keeps a hardware stack of predicted return addresses for the fetch side of a branch predictor. When a call-type branch is predicted and writes the link register of the active instruction set, the block pushes the return address. It stores the instruction-set flag (32-bit or 64-bit) in the same entry. When a return is predicted, the top entry gives fetch both the target and the instruction-set state that goes with it. The stack then pops, so the entry below it becomes visible on the next cycle.

The stack is a circular buffer of a configurable depth. On overflow, the oldest entry is lost and the newest ones are kept. The predictor exposes its top pointer and its occupancy so that the surrounding logic can checkpoint them for each predicted branch. On a mispredict, those values can be loaded back in one cycle. Because predictions cover 32-byte fetch windows, the block also provides the window-aligned form of the target.

Top module: `ras_predictor`

## Requirements
- R1: After a synchronous active-low reset, `pred_valid_o` is 0, `pred_target_o` is 0, and `ckpt_ptr_o` and `ckpt_cnt_o` are 0.
- R2: A call pushes only when its link register number matches the active state: 14 when `call_isa64_i` is 0 (32-bit state), or 30 when `call_isa64_i` is 1 (64-bit state). Any other register number leaves the pointer, the count and the outputs unchanged, including 30 in 32-bit state and 14 in 64-bit state.
- R3: In the cycle after a push, `pred_valid_o` is 1, `pred_target_o` holds the pushed return address and `pred_isa64_o` holds the pushed state flag.
- R4: A return pops the stack in last-in first-out order. During the return cycle the outputs show the entry being consumed. From the next cycle, the count drops by one and the entry below is shown.
- R5: When the stack is empty, `pred_valid_o`, `pred_isa64_o`, `pred_target_o` and `pred_window_o` are all 0. A return on an empty stack changes neither the pointer nor the count.
- R6: A push and a return in the same cycle replace the top entry in place and keep the pointer and the count. On an empty stack, the pair leaves a single entry holding the pushed address.
- R7: A push onto a full stack (count equal to DEPTH) overwrites the oldest entry and the count stays at DEPTH. Subsequent returns deliver the newest DEPTH addresses in reverse order, and then the stack is empty.
- R8: `ckpt_ptr_o` and `ckpt_cnt_o` give the current top pointer and count. Asserting `recover_i` loads `recover_ptr_i` and `recover_cnt_i` by the next cycle, and a call or return in that same cycle is ignored.
- R9: Bit 0 of `pred_target_o` is always 0. In 64-bit state, bit 1 of the pushed address is also dropped, so the target returned for such an entry has bits 1:0 equal to 0.
- R10: `pred_window_o` equals `pred_target_o` with its low log2(WIN_BYTES) bits cleared (the low 5 bits for the default window of 32 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | A call-type branch is predicted this cycle |
| call_link_reg_i | input | 5 | Destination register number of the call |
| call_isa64_i | input | 1 | State of the call: 1 = 64-bit, 0 = 32-bit |
| call_ret_addr_i | input | ADDR_W | Return address to push |
| ret_i | input | 1 | A return is predicted this cycle |
| recover_i | input | 1 | Restore a checkpoint after a mispredict |
| recover_ptr_i | input | PTR_W | Checkpointed top pointer |
| recover_cnt_i | input | CNT_W | Checkpointed occupancy |
| pred_valid_o | output | 1 | The stack holds at least one entry |
| pred_target_o | output | ADDR_W | Predicted return target |
| pred_isa64_o | output | 1 | State flag stored with the target |
| pred_window_o | output | ADDR_W | Target aligned to the fetch window |
| ckpt_ptr_o | output | PTR_W | Current top pointer, for checkpointing |
| ckpt_cnt_o | output | CNT_W | Current occupancy, for checkpointing |

## Verification
The assertions check every cycle that:
- a qualifying call shows its address and state flag on the next cycle;
- a call to a non-link register leaves the pointer and the count unchanged;
- the count never exceeds the depth and stays at the depth on overflow;
- a lone return lowers the count by one, and a paired push and return keep it;
- a recovery loads the checkpoint;
- the empty outputs are zero, and the alignment and window rules hold.

Only the directed scenarios can show the full last-in first-out order across many entries. The same holds for which entries survive a wrap-around on overflow, and for the target the stack returns after a recovery that discards newer pushes.

// File: rtl/ras_pkg.sv
// Shared constants and types of the return address stack predictor.
package ras_pkg;
    localparam int unsigned     LINK_IDX_W   = 5;
    localparam logic [4:0]      LINK_REG_A32 = 5'd14;
    localparam logic [4:0]      LINK_REG_A64 = 5'd30;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stack_op_e;
endpackage

// File: rtl/ras_call_filter.sv
// Decides whether a predicted call writes the link register of its own
// instruction set and so must push a return address.
// Assumes: isa64_i = 1 means 64-bit state, 0 means 32-bit state.
module ras_call_filter
    import ras_pkg::*;
(
    input  logic                  call_i,
    input  logic [LINK_IDX_W-1:0] link_reg_i,
    input  logic                  isa64_i,
    output logic                  push_o
);
    logic [LINK_IDX_W-1:0] active_lr;

    // Select the link register of the active state and compare.
    always_comb begin
        active_lr = isa64_i ? LINK_REG_A64 : LINK_REG_A32;
        push_o    = call_i && (link_reg_i == active_lr);
    end
endmodule

// File: rtl/ras_addr_codec.sv
// Packs a return address into its stored field and expands it back.
// Bit 0 is never stored; bit 1 is forced to zero for 64-bit state.
// Assumes: ADDR_W >= 3.
module ras_addr_codec #(
    parameter int unsigned ADDR_W = 48,
    localparam int unsigned FLD_W = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_isa64_i,
    output logic [FLD_W-1:0]  wr_field_o,
    input  logic [FLD_W-1:0]  rd_field_i,
    output logic [ADDR_W-1:0] rd_addr_o
);
    // Drop bit 0, and bit 1 when the state only allows word alignment.
    always_comb wr_field_o = {wr_addr_i[ADDR_W-1:2], wr_addr_i[1] & ~wr_isa64_i};

    // Re-insert the halfword zero on the read side.
    always_comb rd_addr_o = {rd_field_i, 1'b0};
endmodule

// File: rtl/ras_ptr_ctrl.sv
// Top pointer and occupancy of the circular stack. Handles push, pop,
// in-place replacement, overflow wrap and checkpoint recovery.
// Assumes: DEPTH >= 2; recovery has priority over any stack operation.
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stack_op_e        op_i,
    input  logic             recover_i,
    input  logic [PTR_W-1:0] recover_ptr_i,
    input  logic [CNT_W-1:0] recover_cnt_i,
    output logic [PTR_W-1:0] tos_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] tos_q, tos_d, up_ptr, down_ptr;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Neighbouring slots with wrap for any depth.
    always_comb begin
        up_ptr   = (tos_q == LAST_IDX) ? '0 : tos_q + PTR_W'(1);
        down_ptr = (tos_q == '0) ? LAST_IDX : tos_q - PTR_W'(1);
    end

    // Next pointer, count and write slot for the requested operation.
    always_comb begin
        tos_d    = tos_q;
        cnt_d    = cnt_q;
        wr_en_o  = 1'b0;
        wr_idx_o = up_ptr;
        if (recover_i) begin
            tos_d = recover_ptr_i;
            cnt_d = (recover_cnt_i > FULL_CNT) ? FULL_CNT : recover_cnt_i;
        end else begin
            unique case (op_i)
                OP_PUSH: begin
                    wr_en_o = 1'b1;
                    tos_d   = up_ptr;
                    cnt_d   = (cnt_q == FULL_CNT) ? cnt_q : cnt_q + CNT_W'(1);
                end
                OP_POP: begin
                    if (cnt_q != '0) begin
                        tos_d = down_ptr;
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                OP_SWAP: begin
                    wr_en_o  = 1'b1;
                    wr_idx_o = tos_q;
                    if (cnt_q == '0) cnt_d = CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_q <= '0;
            cnt_q <= '0;
        end else begin
            tos_q <= tos_d;
            cnt_q <= cnt_d;
        end
    end

    assign tos_o = tos_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/ras_storage.sv
// Entry array of the stack: one write port, one combinational read port.
// Assumes: entries need no reset, since validity comes from the count.
module ras_storage #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned ENT_W = 48
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [ENT_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [ENT_W-1:0] rd_data_o
);
    logic [ENT_W-1:0] ent_q [DEPTH];
    logic [DEPTH-1:0] ent_we;

    // One-hot write enable for each slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign ent_we[g] = wr_en_i && (wr_idx_i == PTR_W'(g));
    end

    // Slot registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_we[i]) ent_q[i] <= wr_data_i;
        end
    end

    // Read the addressed slot.
    always_comb rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/ras_predictor.sv
// Return address stack for a fetch-side branch predictor. Pushes return
// address plus instruction-set flag on qualifying calls, exposes the top
// entry as the return prediction, pops on returns, and recovers a
// checkpointed pointer and count after a mispredict.
// Assumes: recover values come from earlier ckpt_* outputs.
module ras_predictor
    import ras_pkg::*;
#(
    parameter int unsigned ADDR_W    = 48,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned WIN_BYTES = 32,
    localparam int unsigned PTR_W    = $clog2(DEPTH),
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  call_i,
    input  logic [LINK_IDX_W-1:0] call_link_reg_i,
    input  logic                  call_isa64_i,
    input  logic [ADDR_W-1:0]     call_ret_addr_i,
    input  logic                  ret_i,
    input  logic                  recover_i,
    input  logic [PTR_W-1:0]      recover_ptr_i,
    input  logic [CNT_W-1:0]      recover_cnt_i,
    output logic                  pred_valid_o,
    output logic [ADDR_W-1:0]     pred_target_o,
    output logic                  pred_isa64_o,
    output logic [ADDR_W-1:0]     pred_window_o,
    output logic [PTR_W-1:0]      ckpt_ptr_o,
    output logic [CNT_W-1:0]      ckpt_cnt_o
);
    localparam int unsigned FLD_W   = ADDR_W - 1;
    localparam int unsigned ENT_W   = FLD_W + 1;
    localparam int unsigned WIN_LSB = $clog2(WIN_BYTES);

    logic             push_req;
    stack_op_e        op;
    logic [PTR_W-1:0] tos, wr_idx;
    logic [CNT_W-1:0] cnt;
    logic             wr_en;
    logic [FLD_W-1:0] wr_field;
    logic [ENT_W-1:0] rd_ent;
    logic [ADDR_W-1:0] rd_addr;

    ras_call_filter u_filter (
        .call_i     (call_i),
        .link_reg_i (call_link_reg_i),
        .isa64_i    (call_isa64_i),
        .push_o     (push_req)
    );

    // Map push and return requests to one stack operation.
    always_comb begin
        unique case ({push_req, ret_i})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_HOLD;
        endcase
    end

    ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_i          (op),
        .recover_i     (recover_i),
        .recover_ptr_i (recover_ptr_i),
        .recover_cnt_i (recover_cnt_i),
        .tos_o         (tos),
        .cnt_o         (cnt),
        .wr_en_o       (wr_en),
        .wr_idx_o      (wr_idx)
    );

    ras_addr_codec #(.ADDR_W(ADDR_W)) u_codec (
        .wr_addr_i  (call_ret_addr_i),
        .wr_isa64_i (call_isa64_i),
        .wr_field_o (wr_field),
        .rd_field_i (rd_ent[FLD_W-1:0]),
        .rd_addr_o  (rd_addr)
    );

    ras_storage #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ENT_W(ENT_W)) u_mem (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i ({call_isa64_i, wr_field}),
        .rd_idx_i  (tos),
        .rd_data_o (rd_ent)
    );

    // Prediction outputs, forced to zero while the stack is empty.
    always_comb begin
        pred_valid_o  = (cnt != '0);
        pred_target_o = pred_valid_o ? rd_addr : '0;
        pred_isa64_o  = pred_valid_o & rd_ent[ENT_W-1];
        pred_window_o = {pred_target_o[ADDR_W-1:WIN_LSB], {WIN_LSB{1'b0}}};
    end

    assign ckpt_ptr_o = tos;
    assign ckpt_cnt_o = cnt;
endmodule

// File: rtl/ras_checker.sv
// Cycle-by-cycle properties of the return address stack, bound to the top.
module ras_checker #(
    parameter int unsigned ADDR_W    = 48,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned WIN_BYTES = 32,
    localparam int unsigned PTR_W    = $clog2(DEPTH),
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
    localparam int unsigned WIN_LSB  = $clog2(WIN_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic [4:0]        call_link_reg_i,
    input logic              call_isa64_i,
    input logic [ADDR_W-1:0] call_ret_addr_i,
    input logic              ret_i,
    input logic              recover_i,
    input logic [PTR_W-1:0]  recover_ptr_i,
    input logic [CNT_W-1:0]  recover_cnt_i,
    input logic              pred_valid_o,
    input logic [ADDR_W-1:0] pred_target_o,
    input logic              pred_isa64_o,
    input logic [ADDR_W-1:0] pred_window_o,
    input logic [PTR_W-1:0]  ckpt_ptr_o,
    input logic [CNT_W-1:0]  ckpt_cnt_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic lr_hit;
    assign lr_hit = call_i && (call_link_reg_i == (call_isa64_i ? 5'd30 : 5'd14));

    p_push_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lr_hit && !ret_i && !recover_i |=>
            pred_valid_o && pred_target_o[ADDR_W-1:2] == $past(call_ret_addr_i[ADDR_W-1:2])
            && pred_isa64_o == $past(call_isa64_i));

    p_ignore_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        call_i && !lr_hit && !ret_i && !recover_i |=>
            $stable(ckpt_ptr_o) && $stable(ckpt_cnt_o));

    p_pop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && !lr_hit && !recover_i && ckpt_cnt_o != '0 |=>
            ckpt_cnt_o == $past(ckpt_cnt_o) - CNT_W'(1));

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && !lr_hit && !recover_i && ckpt_cnt_o == '0 |=>
            !pred_valid_o && $stable(ckpt_ptr_o));

    p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_o |-> pred_target_o == '0 && !pred_isa64_o);

    p_swap_inplace_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i && lr_hit && !recover_i && ckpt_cnt_o != '0 |=>
            $stable(ckpt_ptr_o) && $stable(ckpt_cnt_o));

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_cnt_o <= FULL_CNT);

    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lr_hit && !ret_i && !recover_i && ckpt_cnt_o == FULL_CNT |=>
            ckpt_cnt_o == FULL_CNT);

    p_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recover_i |=> ckpt_ptr_o == $past(recover_ptr_i) && ckpt_cnt_o == $past(recover_cnt_i));

    p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_target_o[0] && (pred_isa64_o -> !pred_target_o[1]));

    p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pred_window_o[ADDR_W-1:WIN_LSB] == pred_target_o[ADDR_W-1:WIN_LSB]
        && pred_window_o[WIN_LSB-1:0] == '0);
endmodule

bind ras_predictor ras_checker #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .call_i          (call_i),
    .call_link_reg_i (call_link_reg_i),
    .call_isa64_i    (call_isa64_i),
    .call_ret_addr_i (call_ret_addr_i),
    .ret_i           (ret_i),
    .recover_i       (recover_i),
    .recover_ptr_i   (recover_ptr_i),
    .recover_cnt_i   (recover_cnt_i),
    .pred_valid_o    (pred_valid_o),
    .pred_target_o   (pred_target_o),
    .pred_isa64_o    (pred_isa64_o),
    .pred_window_o   (pred_window_o),
    .ckpt_ptr_o      (ckpt_ptr_o),
    .ckpt_cnt_o      (ckpt_cnt_o)
);

// File: tb/ras_predictor_tb.sv
// Directed bench for ras_predictor: one task per scenario.
module ras_predictor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 48;
    localparam int DEPTH = 16;
    localparam int PW    = 4;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          call_i;
    logic [4:0]    call_link_reg_i;
    logic          call_isa64_i;
    logic [AW-1:0] call_ret_addr_i;
    logic          ret_i;
    logic          recover_i;
    logic [PW-1:0] recover_ptr_i;
    logic [CW-1:0] recover_cnt_i;
    logic          pred_valid_o;
    logic [AW-1:0] pred_target_o;
    logic          pred_isa64_o;
    logic [AW-1:0] pred_window_o;
    logic [PW-1:0] ckpt_ptr_o;
    logic [CW-1:0] ckpt_cnt_o;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;

    ras_predictor #(.ADDR_W(AW), .DEPTH(DEPTH), .WIN_BYTES(32)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .call_i(call_i), .call_link_reg_i(call_link_reg_i),
        .call_isa64_i(call_isa64_i), .call_ret_addr_i(call_ret_addr_i),
        .ret_i(ret_i), .recover_i(recover_i),
        .recover_ptr_i(recover_ptr_i), .recover_cnt_i(recover_cnt_i),
        .pred_valid_o(pred_valid_o), .pred_target_o(pred_target_o),
        .pred_isa64_o(pred_isa64_o), .pred_window_o(pred_window_o),
        .ckpt_ptr_o(ckpt_ptr_o), .ckpt_cnt_o(ckpt_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        call_i = 0; call_link_reg_i = '0; call_isa64_i = 0; call_ret_addr_i = '0;
        ret_i = 0; recover_i = 0; recover_ptr_i = '0; recover_cnt_i = '0;
    endtask

    // Inputs change at the falling edge; one call passes one rising edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_call(input logic [AW-1:0] a, input logic isa64, input logic [4:0] lr);
        call_i = 1; call_ret_addr_i = a; call_isa64_i = isa64; call_link_reg_i = lr;
        tick(); idle();
    endtask

    task automatic do_ret();
        ret_i = 1; tick(); idle();
    endtask

    task automatic expect_top(input string req, input logic [AW-1:0] a, input logic isa64);
        chk({req, " valid"}, 64'(pred_valid_o), 64'(1));
        chk({req, " target"}, 64'(pred_target_o), 64'(a));
        chk({req, " isa"}, 64'(pred_isa64_o), 64'(isa64));
    endtask

    task automatic t_reset();
        chk("R1 valid", 64'(pred_valid_o), 64'(0));
        chk("R1 target", 64'(pred_target_o), 64'(0));
        chk("R1 ptr", 64'(ckpt_ptr_o), 64'(0));
        chk("R1 cnt", 64'(ckpt_cnt_o), 64'(0));
    endtask

    task automatic t_push_pop();
        do_call(48'h0000_1234_5670, 1'b1, 5'd30);
        expect_top("R3 first", 48'h0000_1234_5670, 1'b1);
        do_call(48'h0000_0000_8a42, 1'b0, 5'd14);
        expect_top("R3 second", 48'h0000_0000_8a42, 1'b0);
        chk("R4 cnt two", 64'(ckpt_cnt_o), 64'(2));
        ret_i = 1;
        expect_top("R4 during ret", 48'h0000_0000_8a42, 1'b0);
        tick(); idle();
        expect_top("R4 below", 48'h0000_1234_5670, 1'b1);
        chk("R4 cnt one", 64'(ckpt_cnt_o), 64'(1));
        do_ret();
        chk("R5 valid after last", 64'(pred_valid_o), 64'(0));
        chk("R5 target zero", 64'(pred_target_o), 64'(0));
        chk("R5 window zero", 64'(pred_window_o), 64'(0));
    endtask

    task automatic t_link_keys();
        do_call(48'h0000_0000_1000, 1'b0, 5'd30);
        chk("R2 r30 in 32-bit", 64'(ckpt_cnt_o), 64'(0));
        do_call(48'h0000_0000_1000, 1'b1, 5'd14);
        chk("R2 r14 in 64-bit", 64'(ckpt_cnt_o), 64'(0));
        do_call(48'h0000_0000_1000, 1'b1, 5'd5);
        chk("R2 other reg", 64'(ckpt_cnt_o), 64'(0));
        chk("R2 ptr kept", 64'(ckpt_ptr_o), 64'(0));
        chk("R2 valid low", 64'(pred_valid_o), 64'(0));
        do_call(48'h0000_0000_2224, 1'b0, 5'd14);
        expect_top("R2 r14 in 32-bit", 48'h0000_0000_2224, 1'b0);
        do_ret();
    endtask

    task automatic t_empty_pop();
        logic [PW-1:0] p;
        p = ckpt_ptr_o;
        do_ret();
        chk("R5 empty pop cnt", 64'(ckpt_cnt_o), 64'(0));
        chk("R5 empty pop ptr", 64'(ckpt_ptr_o), 64'(p));
        chk("R5 empty pop valid", 64'(pred_valid_o), 64'(0));
        chk("R5 empty isa", 64'(pred_isa64_o), 64'(0));
    endtask

    task automatic t_replace();
        logic [PW-1:0] p;
        do_call(48'h0000_0000_a000, 1'b1, 5'd30);
        do_call(48'h0000_0000_b000, 1'b1, 5'd30);
        p = ckpt_ptr_o;
        call_i = 1; call_ret_addr_i = 48'h0000_0000_c002; call_isa64_i = 0;
        call_link_reg_i = 5'd14; ret_i = 1;
        tick(); idle();
        chk("R6 ptr kept", 64'(ckpt_ptr_o), 64'(p));
        chk("R6 cnt kept", 64'(ckpt_cnt_o), 64'(2));
        expect_top("R6 replaced", 48'h0000_0000_c002, 1'b0);
        do_ret();
        expect_top("R6 below intact", 48'h0000_0000_a000, 1'b1);
        do_ret();
        call_i = 1; call_ret_addr_i = 48'h0000_0000_d000; call_isa64_i = 1;
        call_link_reg_i = 5'd30; ret_i = 1;
        tick(); idle();
        chk("R6 empty swap cnt", 64'(ckpt_cnt_o), 64'(1));
        expect_top("R6 empty swap", 48'h0000_0000_d000, 1'b1);
        do_ret();
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= DEPTH + 2; i++)
            do_call(48'h0000_4000_0000 + 48'(i) * 48'd64, 1'b1, 5'd30);
        chk("R7 cnt saturates", 64'(ckpt_cnt_o), 64'(DEPTH));
        for (int i = DEPTH + 2; i >= 3; i--) begin
            expect_top("R7 lifo", 48'h0000_4000_0000 + 48'(i) * 48'd64, 1'b1);
            do_ret();
        end
        chk("R7 empty after depth pops", 64'(pred_valid_o), 64'(0));
    endtask

    task automatic t_recover();
        logic [PW-1:0] sp;
        logic [CW-1:0] sc;
        do_call(48'h0000_0000_7710, 1'b1, 5'd30);
        sp = ckpt_ptr_o; sc = ckpt_cnt_o;
        do_call(48'h0000_0000_8810, 1'b1, 5'd30);
        do_call(48'h0000_0000_9910, 1'b0, 5'd14);
        recover_i = 1; recover_ptr_i = sp; recover_cnt_i = sc;
        call_i = 1; call_ret_addr_i = 48'h0000_0000_eee0; call_isa64_i = 1; call_link_reg_i = 5'd30;
        tick(); idle();
        chk("R8 ptr restored", 64'(ckpt_ptr_o), 64'(sp));
        chk("R8 cnt restored", 64'(ckpt_cnt_o), 64'(sc));
        expect_top("R8 top after recover", 48'h0000_0000_7710, 1'b1);
        do_ret();
        chk("R8 empty after", 64'(pred_valid_o), 64'(0));
    endtask

    task automatic t_align_window();
        do_call(48'h0000_0000_1006, 1'b1, 5'd30);
        expect_top("R9 64-bit drops bit1", 48'h0000_0000_1004, 1'b1);
        do_call(48'h0000_0000_2007, 1'b0, 5'd14);
        expect_top("R9 32-bit keeps bit1", 48'h0000_0000_2006, 1'b0);
        do_call(48'h0000_0000_12f4, 1'b1, 5'd30);
        chk("R10 window", 64'(pred_window_o), 64'(48'h0000_0000_12e0));
        do_ret(); do_ret(); do_ret();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_push_pop();
        t_link_keys();
        t_empty_pop();
        t_replace();
        t_overflow();
        t_recover();
        t_align_window();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule